// File: doc/BRIEF.md
# Slotted Stereo Serial Audio Port

This block moves 16-bit two's-complement stereo samples between a parallel core interface and a pair of serial data lines. A frame spans 64 bit clocks and holds two 32-bit slots. Channel one travels while word-select is high, and channel two travels while it is low. In each slot only 16 bit times carry data. Two static selects set the placement of those bits and their order. The placement select puts them in the first half or the second half of the slot. The order select sends and receives either the most significant bit or the least significant bit first. Both selects apply to the transmit path and the receive path alike.

The port can own the serial clocks or follow them. When it owns them, it divides the system clock to make the bit clock and counts bit clocks to make word-select. When it follows them, it synchronises the external bit clock, word-select and serial input into the system clock domain. It then works on the detected bit-clock edges and re-aligns its slot position at every word-select transition. Transmit samples are taken from the core at the start of each frame. The two received samples are handed back together with a single-cycle strobe when the next frame begins.

Top module: `sap_port`

## Requirements
- R1: In master mode the bit clock has a period of DIV system clocks and idles high out of reset. Word-select changes only together with a bit-clock falling edge. It is high for the first 32 bit times of each 64-bit frame and low for the last 32.
- R2: The clock drive enable `clk_oe` equals `master_en`. It is 1 when the port drives the bit clock and word-select, and 0 when it follows the external clocks.
- R3: With `slot_front`=1, the 16 data bits occupy bit times 0..15 of the slot. Bit time 0 is the first bit after the word-select edge.
- R4: With `slot_front`=0, the 16 data bits occupy bit times 16..31 of the slot.
- R5: With `msb_first`=1, the first data bit time carries bit 15 and the last carries bit 0. With `msb_first`=0 the order is reversed, so bit 0 goes first.
- R6: Serial input is sampled on the bit-clock rising edge, using the same slot placement and bit order as the output. Channel-one bits land in `rx_left` and channel-two bits land in `rx_right`.
- R7: During the 16 bit times of a slot outside the data half, `sdo` is 0 and the value on `sdi` has no effect on the received samples.
- R8: In slave mode, the first bit time after any word-select transition is bit 0 of a new slot. Channel one follows a rising transition and channel two follows a falling one. No data is placed or captured before the first transition.
- R9: When a frame start is detected (word-select rising at a bit-clock fall), `rx_valid` pulses for exactly one system clock, and `rx_left`/`rx_right` then hold the samples received in the frame just completed. There is no pulse at the first frame start after reset.
- R10: `tx_left` and `tx_right` are sampled at the frame start. Changing them later in the frame does not alter the bits sent in that frame.
- R11: After reset `rx_valid`, `rx_left`, `rx_right` and `sdo` are 0, and in master mode `bclk_out` is 1 and `ws_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1: generate bit clock and word-select; 0: follow external clocks |
| slot_front | input | 1 | 1: data in first half of slot; 0: data in second half |
| msb_first | input | 1 | 1: MSB first; 0: LSB first |
| bclk_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word-select (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated word-select (master mode) |
| clk_oe | output | 1 | Drive enable for the bit-clock and word-select pads |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| tx_left | input | 16 | Channel-one transmit sample |
| tx_right | input | 16 | Channel-two transmit sample |
| rx_left | output | 16 | Channel-one received sample |
| rx_right | output | 16 | Channel-two received sample |
| rx_valid | output | 1 | One-cycle strobe: new received pair available |

## Verification
Most internal faults in this port show up on `sdo` within one bit time. A slot position that is off by one, a wrong channel select or a swapped bit index puts a wrong value on `sdo` at the next bit-clock fall. The bench compares `sdo` against its own frame model on every system clock, so such a fault is caught at once. A fault in the receive path is hidden until the frame ends. It then appears as a wrong `rx_left`/`rx_right` value at the `rx_valid` strobe, or as a strobe that is missing, extra or mistimed. A slave-mode alignment error shows within one slot of the first word-select transition.

// File: rtl/sap_pkg.sv
package sap_pkg;

  // True when slot bit time 'pos' carries one of the data bits.
  function automatic logic in_data_window(input int pos, input logic front,
                                          input int data_w, input int slot_w);
    if (front) return (pos < data_w);
    return (pos >= slot_w - data_w) && (pos < slot_w);
  endfunction

  // Sample bit number sent or received at slot bit time 'pos'.
  function automatic int data_bit_index(input int pos, input logic front,
                                        input logic msb, input int data_w,
                                        input int slot_w);
    int k;
    k = front ? pos : pos - (slot_w - data_w);
    return msb ? (data_w - 1 - k) : k;
  endfunction

endpackage

// File: rtl/sap_clkgen.sv
module sap_clkgen #(
  parameter int DIV    = 4,
  parameter int SLOT_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic bclk,
  output logic ws,
  output logic fall_evt,
  output logic rise_evt,
  output logic ws_next
);
  localparam int HALF  = DIV / 2;
  localparam int HW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int FRAME = 2 * SLOT_W;
  localparam int FW    = $clog2(FRAME);

  logic [HW-1:0] div_q;
  logic [FW-1:0] fcnt_q;
  logic [FW-1:0] fcnt_inc;
  logic          half_done;

  assign half_done = enable && (div_q == HW'(HALF - 1));
  assign fall_evt  = half_done && bclk;
  assign rise_evt  = half_done && !bclk;
  assign fcnt_inc  = fcnt_q + 1'b1;
  assign ws_next   = ({1'b0, fcnt_inc} < (FW + 1)'(SLOT_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk   <= 1'b1;
      ws     <= 1'b0;
      fcnt_q <= '1;
    end else if (!enable) begin
      div_q  <= '0;
      bclk   <= 1'b1;
      ws     <= 1'b0;
      fcnt_q <= '1;
    end else begin
      div_q <= half_done ? '0 : div_q + 1'b1;
      if (half_done) bclk <= ~bclk;
      if (fall_evt) begin
        fcnt_q <= fcnt_inc;
        ws     <= ws_next;
      end
    end
  end

  AST_WS_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    enable && $stable(enable) && !$stable(ws) |-> !bclk); // R1

endmodule

// File: rtl/sap_sync.sv
module sap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic ws_o,
  output logic sd_o,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int NSIG = 3;

  logic [STAGES-1:0][NSIG-1:0] stage_q;
  logic [NSIG-1:0]             tail;
  logic                        bclk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      bclk_last <= 1'b0;
    end else begin
      stage_q[0] <= {sd_i, ws_i, bclk_i};
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      bclk_last <= stage_q[STAGES-1][0];
    end
  end

  assign tail     = stage_q[STAGES-1];
  assign rise_evt = tail[0] && !bclk_last;
  assign fall_evt = !tail[0] && bclk_last;
  assign ws_o     = tail[1];
  assign sd_o     = tail[2];

endmodule

// File: rtl/sap_slot_tracker.sv
module sap_slot_tracker #(
  parameter int SLOT_W = 32,
  localparam int PW    = $clog2(SLOT_W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          fall_evt,
  input  logic          ws_now,
  output logic [PW-1:0] cur_pos,
  output logic          cur_chan,
  output logic          cur_aligned,
  output logic [PW-1:0] nxt_pos,
  output logic          nxt_chan,
  output logic          nxt_aligned,
  output logic          frame_start
);
  logic ws_last;
  logic seen;
  logic ws_edge;

  // The first level seen in slave mode only primes ws_last.
  assign ws_edge     = fall_evt && (seen ? (ws_now != ws_last) : (master && ws_now));
  assign frame_start = ws_edge && ws_now;
  assign nxt_aligned = cur_aligned || ws_edge;
  assign nxt_chan    = ws_edge ? !ws_now : cur_chan;
  assign nxt_pos     = ws_edge ? '0 :
                       (cur_pos == PW'(SLOT_W)) ? cur_pos : cur_pos + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_last     <= 1'b0;
      seen        <= 1'b0;
      cur_pos     <= PW'(SLOT_W);
      cur_chan    <= 1'b0;
      cur_aligned <= 1'b0;
    end else if (fall_evt) begin
      ws_last     <= ws_now;
      seen        <= 1'b1;
      cur_pos     <= nxt_pos;
      cur_chan    <= nxt_chan;
      cur_aligned <= nxt_aligned;
    end
  end

  AST_REALIGN_ON_WS: assert property (@(posedge clk) disable iff (!rst_n)
    ws_edge |=> (cur_pos == '0)); // R8
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cur_pos <= PW'(SLOT_W)); // R8

endmodule

// File: rtl/sap_datapath.sv
module sap_datapath
  import sap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SLOT_W = 32,
  localparam int PW    = $clog2(SLOT_W) + 1,
  localparam int IW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_front,
  input  logic              msb_first,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              sdi_bit,
  input  logic [PW-1:0]     cur_pos,
  input  logic              cur_chan,
  input  logic              cur_aligned,
  input  logic [PW-1:0]     nxt_pos,
  input  logic              nxt_chan,
  input  logic              nxt_aligned,
  input  logic              frame_start,
  input  logic [DATA_W-1:0] tx_left,
  input  logic [DATA_W-1:0] tx_right,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_left,
  output logic [DATA_W-1:0] rx_right,
  output logic              rx_valid
);
  logic [1:0][DATA_W-1:0] tx_q;
  logic [1:0][DATA_W-1:0] rx_acc;
  logic [DATA_W-1:0]      tx_word;
  logic                   nxt_win, cur_win;
  logic [IW-1:0]          nxt_idx, cur_idx;
  logic                   armed;
  logic                   publish;

  assign nxt_win = nxt_aligned &&
                   in_data_window(int'(nxt_pos), slot_front, DATA_W, SLOT_W);
  assign cur_win = cur_aligned &&
                   in_data_window(int'(cur_pos), slot_front, DATA_W, SLOT_W);
  assign nxt_idx = IW'(data_bit_index(int'(nxt_pos), slot_front, msb_first, DATA_W, SLOT_W));
  assign cur_idx = IW'(data_bit_index(int'(cur_pos), slot_front, msb_first, DATA_W, SLOT_W));

  // At a frame start the first bit comes straight from the core port.
  assign tx_word = frame_start ? tx_left : tx_q[nxt_chan];
  assign publish = frame_start && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_acc   <= '0;
      sdo      <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
      armed    <= 1'b0;
    end else begin
      rx_valid <= publish;
      if (fall_evt) begin
        sdo <= nxt_win ? tx_word[nxt_idx] : 1'b0;
        if (frame_start) begin
          tx_q  <= {tx_right, tx_left};
          armed <= 1'b1;
        end
      end
      if (publish) begin
        rx_left  <= rx_acc[0];
        rx_right <= rx_acc[1];
      end
      if (rise_evt && cur_win) rx_acc[cur_chan][cur_idx] <= sdi_bit;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9
  AST_IDLE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_win |-> !sdo); // R7
  AST_TX_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(tx_q)); // R10

endmodule

// File: rtl/sap_port.sv
module sap_port #(
  parameter int DATA_W      = 16,
  parameter int SLOT_W      = 32,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = $clog2(SLOT_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              slot_front,
  input  logic              msb_first,
  input  logic              bclk_in,
  input  logic              ws_in,
  output logic              bclk_out,
  output logic              ws_out,
  output logic              clk_oe,
  input  logic              sdi,
  output logic              sdo,
  input  logic [DATA_W-1:0] tx_left,
  input  logic [DATA_W-1:0] tx_right,
  output logic [DATA_W-1:0] rx_left,
  output logic [DATA_W-1:0] rx_right,
  output logic              rx_valid
);
  logic          gen_fall, gen_rise, gen_ws_next;
  logic          sl_fall, sl_rise, sl_ws, sl_sd;
  logic          fall_evt, rise_evt, ws_now, sdi_bit;
  logic [PW-1:0] cur_pos, nxt_pos;
  logic          cur_chan, nxt_chan, cur_aligned, nxt_aligned, frame_start;

  sap_clkgen #(.DIV(DIV), .SLOT_W(SLOT_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .enable(master_en),
    .bclk(bclk_out), .ws(ws_out),
    .fall_evt(gen_fall), .rise_evt(gen_rise), .ws_next(gen_ws_next)
  );

  sap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .bclk_i(bclk_in), .ws_i(ws_in), .sd_i(sdi),
    .ws_o(sl_ws), .sd_o(sl_sd), .rise_evt(sl_rise), .fall_evt(sl_fall)
  );

  assign fall_evt = master_en ? gen_fall    : sl_fall;
  assign rise_evt = master_en ? gen_rise    : sl_rise;
  assign ws_now   = master_en ? gen_ws_next : sl_ws;
  assign sdi_bit  = master_en ? sdi         : sl_sd;
  assign clk_oe   = master_en;

  sap_slot_tracker #(.SLOT_W(SLOT_W)) u_tracker (
    .clk(clk), .rst_n(rst_n), .master(master_en),
    .fall_evt(fall_evt), .ws_now(ws_now),
    .cur_pos(cur_pos), .cur_chan(cur_chan), .cur_aligned(cur_aligned),
    .nxt_pos(nxt_pos), .nxt_chan(nxt_chan), .nxt_aligned(nxt_aligned),
    .frame_start(frame_start)
  );

  sap_datapath #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_datapath (
    .clk(clk), .rst_n(rst_n),
    .slot_front(slot_front), .msb_first(msb_first),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .sdi_bit(sdi_bit),
    .cur_pos(cur_pos), .cur_chan(cur_chan), .cur_aligned(cur_aligned),
    .nxt_pos(nxt_pos), .nxt_chan(nxt_chan), .nxt_aligned(nxt_aligned),
    .frame_start(frame_start),
    .tx_left(tx_left), .tx_right(tx_right),
    .sdo(sdo), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

endmodule

// File: tb/sap_port_tb_top.sv
module sap_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int SL_HALF    = 4;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_en = 1'b1;
  logic        slot_front = 1'b1;
  logic        msb_first = 1'b1;
  logic        bclk_in = 1'b1;
  logic        ws_in = 1'b0;
  logic        sdi = 1'b0;
  logic [15:0] tx_left = '0;
  logic [15:0] tx_right = '0;
  logic        bclk_out, ws_out, clk_oe, sdo, rx_valid;
  logic [15:0] rx_left, rx_right;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sap_port dut_i (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .slot_front(slot_front),
    .msb_first(msb_first), .bclk_in(bclk_in), .ws_in(ws_in),
    .bclk_out(bclk_out), .ws_out(ws_out), .clk_oe(clk_oe),
    .sdi(sdi), .sdo(sdo), .tx_left(tx_left), .tx_right(tx_right),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  function automatic logic [15:0] tx_word(int seed, int f, int ch);
    return 16'((seed * 16'h3B1 + f * 16'h1F35 + ch * 16'h9C4E) ^ 16'hA55A);
  endfunction

  function automatic logic [15:0] rx_word(int seed, int f, int ch);
    return 16'((seed * 16'h0D7 + f * 16'h4E69 + ch * 16'h8123) ^ 16'h36C9);
  endfunction

  // Bit expected at slot bit time s, built as a 32-bit slot image.
  function automatic logic slot_bit(logic [15:0] w, int s, logic front, logic msb);
    logic [15:0] seq;
    logic [31:0] img;
    for (int i = 0; i < 16; i++) seq[i] = msb ? w[i] : w[15-i];
    img = front ? {seq, 16'h0000} : {16'h0000, seq};
    return img[31-s];
  endfunction

  function automatic logic data_time(int s, logic front);
    return front ? (s < 16) : (s >= 16);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic front, input logic msb, input int seed);
    rst_n      = 1'b0;
    master_en  = m;
    slot_front = front;
    msb_first  = msb;
    bclk_in    = 1'b1;
    ws_in      = 1'b0;
    sdi        = 1'b0;
    tx_left    = tx_word(seed, 0, 0);
    tx_right   = tx_word(seed, 0, 1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 reset rx_valid", 32'(rx_valid), 0);
    chk("R11 reset rx_left", 32'(rx_left), 0);
    chk("R11 reset rx_right", 32'(rx_right), 0);
    chk("R11 reset sdo", 32'(sdo), 0);
    chk("R2 clock drive enable", 32'(clk_oe), 32'(m));
    if (m) begin
      chk("R11 reset bclk_out", 32'(bclk_out), 1);
      chk("R11 reset ws_out", 32'(ws_out), 0);
    end
  endtask

  task automatic run_master(input int seed, input logic front, input logic msb, input int nf);
    int   n = -1;
    int   t = 0;
    int   last_t = 0;
    logic prev;
    logic exp_sdo = 1'b0;
    do_reset(1'b1, front, msb, seed);
    prev = bclk_out;
    while (n < nf * 64) begin
      @(negedge clk);
      t++;
      if (prev && !bclk_out) begin
        int p, f, s, ch;
        n++;
        p = n % 64; f = n / 64; s = p % 32; ch = p / 32;
        if (n > 0) chk("R1 bit clock period", 32'(t - last_t), 32'(DIV));
        last_t = t;
        chk("R1 word select level", 32'(ws_out), 32'(p < 32));
        chk("R2 master drive enable", 32'(clk_oe), 1);
        exp_sdo = slot_bit(tx_word(seed, f, ch), s, front, msb);
        if (!data_time(s, front)) chk("R7 idle bit time sdo", 32'(sdo), 32'(exp_sdo));
        else if (p > 20)          chk("R10 latched sample sdo", 32'(sdo), 32'(exp_sdo));
        else if (front)           chk("R3 front slot sdo (R5 order)", 32'(sdo), 32'(exp_sdo));
        else                      chk("R4 rear slot sdo (R5 order)", 32'(sdo), 32'(exp_sdo));
        if (p == 0 && f >= 1) begin
          chk("R9 strobe at frame start", 32'(rx_valid), 1);
          chk("R6 rx_left (R7 idle sdi ignored)", 32'(rx_left), 32'(rx_word(seed, f-1, 0)));
          chk("R6 rx_right (R7 idle sdi ignored)", 32'(rx_right), 32'(rx_word(seed, f-1, 1)));
        end else begin
          chk("R9 no strobe mid frame", 32'(rx_valid), 0);
        end
        sdi = data_time(s, front) ? slot_bit(rx_word(seed, f, ch), s, front, msb) : 1'b1;
        if (p == 20) begin
          tx_left  = tx_word(seed, f + 1, 0);
          tx_right = tx_word(seed, f + 1, 1);
        end
      end else begin
        chk("R9 no strobe between bits", 32'(rx_valid), 0);
        if (n >= 0) chk("R7 sdo held within bit", 32'(sdo), 32'(exp_sdo));
      end
      prev = bclk_out;
    end
  endtask

  task automatic run_slave(input int seed, input logic front, input logic msb, input int nf);
    int total;
    do_reset(1'b0, front, msb, seed);
    total = 42 + nf * 64 + 2;
    for (int b = 0; b < total; b++) begin
      int   fb, p, f, s, ch, nval;
      logic ws_v, exp_o, exp_v, d;
      fb = b - 42;
      p = 0; f = 0; s = 0; ch = 0;
      if (b < 10)      ws_v = 1'b1;
      else if (b < 42) ws_v = 1'b0;
      else             ws_v = ((fb % 64) < 32);
      if (fb >= 0) begin
        p = fb % 64; f = fb / 64; s = p % 32; ch = p / 32;
        exp_o = slot_bit(tx_word(seed, f, ch), s, front, msb);
        d     = data_time(s, front) ? slot_bit(rx_word(seed, f, ch), s, front, msb) : 1'b1;
        exp_v = (p == 0 && f >= 1);
      end else begin
        exp_o = 1'b0;
        d     = 1'b1;
        exp_v = 1'b0;
      end
      bclk_in = 1'b0;
      ws_in   = ws_v;
      sdi     = d;
      if (fb >= 0 && p == 20) begin
        tx_left  = tx_word(seed, f + 1, 0);
        tx_right = tx_word(seed, f + 1, 1);
      end
      nval = 0;
      repeat (SL_HALF) begin
        @(negedge clk);
        if (rx_valid) begin
          nval++;
          if (exp_v) begin
            chk("R8 slave rx_left after realign", 32'(rx_left), 32'(rx_word(seed, f-1, 0)));
            chk("R8 slave rx_right after realign", 32'(rx_right), 32'(rx_word(seed, f-1, 1)));
          end
        end
      end
      chk("R9 slave strobe count", 32'(nval), 32'(exp_v));
      chk("R8 slave sdo", 32'(sdo), 32'(exp_o));
      bclk_in = 1'b1;
      repeat (SL_HALF) begin
        @(negedge clk);
        chk("R9 slave no strobe on high half", 32'(rx_valid), 0);
      end
    end
  endtask

  initial begin
    run_master(1, 1'b1, 1'b1, 3);
    run_master(2, 1'b0, 1'b0, 3);
    run_master(3, 1'b1, 1'b0, 2);
    run_master(4, 1'b0, 1'b1, 2);
    run_slave(5, 1'b0, 1'b1, 3);
    run_slave(6, 1'b1, 1'b0, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule